// File: doc/BRIEF.md
# Control Endpoint FIFO Loopback Controller

This block models the buffer side of a bidirectional control endpoint whose outgoing and incoming packet stores are the same RAM. A CPU byte port loads bytes into the buffer. Two pulse inputs mark the outgoing packet as ready or release a received packet. A test-mode register write starts a self-test. The self-test turns the loaded outgoing packet into a received packet without any bus traffic, so the same bytes can be read back through the receive side.

The self-test is a fixed four-step sequence with one step per clock. First the outgoing byte count is copied into the received byte count. Next the outgoing count is cleared. Then the two packet-ready flags swap. Finally an interrupt pulse is raised if the enable is set. Software then drains the bytes and releases the packet with the serviced input. The self-test is refused while a bus session is active.

Top module: `ep0_loopback`

## Requirements
- R1: While the sequencer is idle and both ready flags are clear, a CPU write stores its byte at buffer position `tx_count`, and `tx_count` then rises by one. At any other time a CPU write changes nothing.
- R2: The buffer holds 64 bytes. An accepted write made when `tx_count` is already 64 stores nothing and leaves the count at 64. It sets `overflow`, which stays set until reset.
- R3: A `set_tx_ready` pulse sets `tx_pkt_ready` when the sequencer is idle and `rx_pkt_ready` is clear. The two ready flags are never set together.
- R4: The self-test starts only on a test-mode write of value 0x40 at an edge where `tx_pkt_ready` is set and `session_active` is low. Any other value, a clear `tx_pkt_ready`, or an active session leaves every output unchanged.
- R5: Let E be the edge that accepts the start. At edge E+1, `rx_count` takes the value of `tx_count`. At E+2, `tx_count` becomes 0. At E+3, `tx_pkt_ready` clears and `rx_pkt_ready` sets.
- R6: At edge E+4, `irq` goes high for exactly one cycle if `irq_enable` is high at that edge. Otherwise `irq` stays low.
- R7: While `rx_pkt_ready` is set, `cpu_rd_data` shows the buffer byte at the read position. Each read strobe advances the position by one, so the loaded bytes come back in the order they were written.
- R8: When the read position has reached `rx_count`, or `rx_pkt_ready` is clear, `cpu_rd_data` is 0 and a read strobe does not move the position.
- R9: A `set_serviced` pulse while `rx_pkt_ready` is set and the sequencer is idle clears `rx_pkt_ready`, `rx_count` and the read position. After that, writes are accepted again from position 0.
- R10: `seq_busy` is high from edge E+1 to edge E+4. While it is high, CPU writes, reads, ready pulses and test-mode writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU write byte |
| cpu_rd_en | input | 1 | CPU byte read strobe |
| cpu_rd_data | output | 8 | Byte at the receive read position, 0 when none is valid |
| set_tx_ready | input | 1 | Pulse: outgoing packet is loaded |
| set_serviced | input | 1 | Pulse: received packet has been drained |
| test_wr_en | input | 1 | Test-mode register write strobe |
| test_wr_data | input | 8 | Test-mode register write value |
| session_active | input | 1 | High while a bus session is in progress |
| irq_enable | input | 1 | Endpoint interrupt enable |
| tx_pkt_ready | output | 1 | Outgoing packet ready flag |
| rx_pkt_ready | output | 1 | Received packet ready flag |
| tx_count | output | 7 | Bytes loaded by the CPU |
| rx_count | output | 7 | Bytes in the received packet |
| overflow | output | 1 | Sticky flag for a write into a full buffer |
| seq_busy | output | 1 | Loopback sequence in progress |
| irq | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the counts and the read position stay within bounds;
- the two ready flags are never set together;
- the overflow flag is sticky;
- `rx_count` takes the earlier `tx_count` on the copy step;
- a read past the end leaves the read position unchanged;
- an `irq` pulse follows every rise of `rx_pkt_ready` exactly when the enable allows it.

Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock:
- the exact step order after the start;
- the rejection of wrong codes, of a start while a session is active, and of a start without a ready packet;
- the byte-for-byte readback;
- the zero returned past the end;
- the inputs ignored while busy.

// File: rtl/ep0lb_pkg.sv
package ep0lb_pkg;

    localparam int unsigned LB_DEPTH     = 64;
    localparam logic [7:0]  LB_TEST_CODE = 8'h40;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_COPY,
        SEQ_CLEAR,
        SEQ_FLAGS,
        SEQ_IRQ
    } seq_state_e;

    typedef struct packed {
        logic tx_ready;
        logic rx_ready;
    } pkt_flags_t;

    function automatic logic is_loop_cmd(input logic [7:0] code);
        return code == LB_TEST_CODE;
    endfunction

endpackage

// File: rtl/ep0lb_ram.sv
module ep0lb_ram #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/ep0lb_ptrs.sv
module ep0lb_ptrs #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              step_copy,
    input  logic              step_clear,
    input  logic              svc_fire,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  rd_ptr,
    output logic              overflow,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_valid
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    assign wr_fire  = wr_req && (tx_count < FULL);
    assign wr_addr  = tx_count[ADDR_W-1:0];
    assign rd_valid = rd_ptr < rx_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_count <= '0;
            rx_count <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_req) begin
                if (tx_count < FULL) begin
                    tx_count <= tx_count + ONE;
                end else begin
                    overflow <= 1'b1;
                end
            end
            if (step_clear) begin
                tx_count <= '0;
            end
            if (step_copy) begin
                rx_count <= tx_count;
            end
            if (svc_fire) begin
                rx_count <= '0;
                rd_ptr   <= '0;
            end else if (rd_req && rd_valid) begin
                rd_ptr <= rd_ptr + ONE;
            end
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= FULL) && (rx_count <= FULL));

    // R2
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(overflow) |-> overflow);

    // R5
    copy_chk: assert property (@(posedge clk) disable iff (rst)
        step_copy |=> (rx_count == $past(tx_count)));

    // R8
    rdptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= rx_count);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && !svc_fire) |=> $stable(rd_ptr));

endmodule

// File: rtl/ep0lb_seq.sv
module ep0lb_seq
    import ep0lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       test_wr,
    input  logic [7:0] test_code,
    input  logic       session_active,
    input  logic       set_tx,
    input  logic       set_svc,
    input  logic       irq_en,
    output pkt_flags_t flags,
    output logic       busy,
    output logic       step_copy,
    output logic       step_clear,
    output logic       svc_fire,
    output logic       irq
);

    seq_state_e state;
    logic       start;

    assign busy       = (state != SEQ_IDLE);
    assign step_copy  = (state == SEQ_COPY);
    assign step_clear = (state == SEQ_CLEAR);
    assign svc_fire   = !busy && set_svc && flags.rx_ready;
    assign start      = !busy && test_wr && is_loop_cmd(test_code)
                        && flags.tx_ready && !session_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (set_tx && !flags.rx_ready) begin
                        flags.tx_ready <= 1'b1;
                    end
                    if (svc_fire) begin
                        flags.rx_ready <= 1'b0;
                    end
                    if (start) begin
                        state <= SEQ_COPY;
                    end
                end
                SEQ_COPY:  state <= SEQ_CLEAR;
                SEQ_CLEAR: state <= SEQ_FLAGS;
                SEQ_FLAGS: begin
                    flags.tx_ready <= 1'b0;
                    flags.rx_ready <= 1'b1;
                    state          <= SEQ_IRQ;
                end
                SEQ_IRQ: begin
                    irq   <= irq_en;
                    state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(flags.tx_ready && flags.rx_ready));

    // R6
    irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.rx_ready) |=> (irq == $past(irq_en)));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/ep0_loopback.sv
module ep0_loopback
    import ep0lb_pkg::*;
#(
    parameter int unsigned DEPTH = LB_DEPTH,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr_en,
    input  logic [7:0]       cpu_wr_data,
    input  logic             cpu_rd_en,
    output logic [7:0]       cpu_rd_data,
    input  logic             set_tx_ready,
    input  logic             set_serviced,
    input  logic             test_wr_en,
    input  logic [7:0]       test_wr_data,
    input  logic             session_active,
    input  logic             irq_enable,
    output logic             tx_pkt_ready,
    output logic             rx_pkt_ready,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             overflow,
    output logic             seq_busy,
    output logic             irq
);

    pkt_flags_t        flags;
    logic              busy;
    logic              step_copy;
    logic              step_clear;
    logic              svc_fire;
    logic              wr_req;
    logic              rd_req;
    logic              wr_fire;
    logic              rd_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  rd_ptr;
    logic [7:0]        ram_q;

    assign wr_req = cpu_wr_en && !busy && !flags.tx_ready && !flags.rx_ready;
    assign rd_req = cpu_rd_en && !busy && flags.rx_ready;

    ep0lb_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .test_wr        (test_wr_en),
        .test_code      (test_wr_data),
        .session_active (session_active),
        .set_tx         (set_tx_ready),
        .set_svc        (set_serviced),
        .irq_en         (irq_enable),
        .flags          (flags),
        .busy           (busy),
        .step_copy      (step_copy),
        .step_clear     (step_clear),
        .svc_fire       (svc_fire),
        .irq            (irq)
    );

    ep0lb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .step_copy  (step_copy),
        .step_clear (step_clear),
        .svc_fire   (svc_fire),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .rd_ptr     (rd_ptr),
        .overflow   (overflow),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .rd_valid   (rd_valid)
    );

    ep0lb_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (cpu_wr_data),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (ram_q)
    );

    assign cpu_rd_data  = (flags.rx_ready && rd_valid) ? ram_q : 8'h00;
    assign tx_pkt_ready = flags.tx_ready;
    assign rx_pkt_ready = flags.rx_ready;
    assign seq_busy     = busy;

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_copy && !step_clear) |=> $stable(tx_count));

endmodule

// File: tb/ep0_loopback_tb.sv
module ep0_loopback_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       cpu_rd_en = 1'b0;
    logic [7:0] cpu_rd_data;
    logic       set_tx_ready = 1'b0;
    logic       set_serviced = 1'b0;
    logic       test_wr_en = 1'b0;
    logic [7:0] test_wr_data = '0;
    logic       session_active = 1'b0;
    logic       irq_enable = 1'b0;
    logic       tx_pkt_ready, rx_pkt_ready, overflow, seq_busy, irq;
    logic [6:0] tx_count, rx_count;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    ep0_loopback u_dut (
        .clk(clk), .rst(rst),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .set_tx_ready(set_tx_ready), .set_serviced(set_serviced),
        .test_wr_en(test_wr_en), .test_wr_data(test_wr_data),
        .session_active(session_active), .irq_enable(irq_enable),
        .tx_pkt_ready(tx_pkt_ready), .rx_pkt_ready(rx_pkt_ready),
        .tx_count(tx_count), .rx_count(rx_count),
        .overflow(overflow), .seq_busy(seq_busy), .irq(irq)
    );

    // behavioural reference model
    int m_buf [64];
    int m_txc = 0, m_rxc = 0, m_rdp = 0, m_phase = 0;
    bit m_ovf = 0, m_txr = 0, m_rxr = 0, m_irq = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_txc = 0; m_rxc = 0; m_rdp = 0; m_phase = 0;
            m_ovf = 0; m_txr = 0; m_rxr = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (m_phase == 0) begin
                if (cpu_wr_en && !m_txr && !m_rxr) begin
                    if (m_txc < 64) begin
                        m_buf[m_txc] = int'(cpu_wr_data);
                        m_txc++;
                    end else begin
                        m_ovf = 1;
                    end
                end
                if (cpu_rd_en && m_rxr && m_rdp < m_rxc) m_rdp++;
                if (set_tx_ready && !m_rxr) m_txr = 1;
                if (set_serviced && m_rxr) begin
                    m_rxr = 0; m_rxc = 0; m_rdp = 0;
                end
                if (test_wr_en && test_wr_data == 8'h40 && m_txr && !session_active)
                    m_phase = 1;
            end else if (m_phase == 1) begin
                m_rxc = m_txc; m_phase = 2;
            end else if (m_phase == 2) begin
                m_txc = 0; m_phase = 3;
            end else if (m_phase == 3) begin
                m_txr = 0; m_rxr = 1; m_phase = 4;
            end else begin
                m_irq = irq_enable; m_phase = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 tx_count", int'(tx_count), m_txc);
            chk("R2 overflow", int'(overflow), int'(m_ovf));
            chk("R3 tx_pkt_ready", int'(tx_pkt_ready), int'(m_txr));
            chk("R5 rx_pkt_ready", int'(rx_pkt_ready), int'(m_rxr));
            chk("R5 rx_count", int'(rx_count), m_rxc);
            chk("R6 irq", int'(irq), int'(m_irq));
            chk("R10 seq_busy", int'(seq_busy), int'(m_phase != 0));
            chk("R7 cpu_rd_data", int'(cpu_rd_data),
                (m_rxr && m_rdp < m_rxc) ? m_buf[m_rdp] : 0);
            if (irq) irq_seen++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); cpu_wr_en = 1'b1; cpu_wr_data = d;
        @(negedge clk); cpu_wr_en = 1'b0;
    endtask

    task automatic rd_byte();
        @(negedge clk); cpu_rd_en = 1'b1;
        @(negedge clk); cpu_rd_en = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); set_tx_ready = 1'b1;
        @(negedge clk); set_tx_ready = 1'b0;
    endtask

    task automatic pulse_svc();
        @(negedge clk); set_serviced = 1'b1;
        @(negedge clk); set_serviced = 1'b0;
    endtask

    task automatic test_wr(input logic [7:0] code);
        @(negedge clk); test_wr_en = 1'b1; test_wr_data = code;
        @(negedge clk); test_wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        // reset state
        chk("R1 reset tx_count", int'(tx_count), 0);
        chk("R3 reset flags", int'({tx_pkt_ready, rx_pkt_ready}), 0);

        // short packet
        for (int i = 0; i < 5; i++) wr_byte(8'hA0 + 8'(i));
        chk("R1 five writes", int'(tx_count), 5);
        pulse_tx();
        wr_byte(8'h55);                      // ignored while tx ready
        chk("R1 write ignored", int'(tx_count), 5);
        test_wr(8'h08);                      // wrong code
        idle(6);
        chk("R4 wrong code", int'(rx_pkt_ready), 0);
        session_active = 1'b1;
        test_wr(8'h40);                      // refused in session
        idle(6);
        chk("R4 session refuse", int'(seq_busy | rx_pkt_ready), 0);
        session_active = 1'b0;
        irq_enable = 1'b1;
        test_wr(8'h40);
        cpu_wr_en = 1'b1; cpu_rd_en = 1'b1;  // ignored while busy
        idle(2);
        chk("R10 busy", int'(seq_busy), 1);
        cpu_wr_en = 1'b0; cpu_rd_en = 1'b0;
        idle(4);
        chk("R5 rx_count", int'(rx_count), 5);
        chk("R5 tx_count cleared", int'(tx_count), 0);
        chk("R6 irq count", irq_seen, 1);
        chk("R7 first byte", int'(cpu_rd_data), 'hA0);
        for (int i = 0; i < 5; i++) rd_byte();
        chk("R8 past end zero", int'(cpu_rd_data), 0);
        rd_byte(); rd_byte();
        chk("R8 still zero", int'(cpu_rd_data), 0);
        test_wr(8'h40);                      // no tx ready
        idle(6);
        chk("R4 no tx ready", int'(rx_count), 5);
        pulse_svc();
        chk("R9 rx cleared", int'(rx_pkt_ready), 0);
        chk("R9 rx_count zero", int'(rx_count), 0);

        // full packet plus overflow, irq disabled
        for (int i = 0; i < 66; i++) wr_byte(8'(i * 7 + 3));
        chk("R2 capped", int'(tx_count), 64);
        chk("R2 overflow set", int'(overflow), 1);
        irq_enable = 1'b0;
        pulse_tx();
        test_wr(8'h40);
        idle(8);
        chk("R6 no irq", irq_seen, 1);
        chk("R5 full count", int'(rx_count), 64);
        for (int i = 0; i < 64; i++) rd_byte();
        chk("R8 end of full", int'(cpu_rd_data), 0);
        pulse_svc();
        wr_byte(8'h3C);
        chk("R9 writes resume", int'(tx_count), 1);
        chk("R2 overflow sticky", int'(overflow), 1);
        idle(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule